// File: doc/BRIEF.md
# Serial LED Switch Register with Status Readback

This block is the digital control core of a multi-channel constant-current LED sink driver, modelled cycle by cycle on a system clock. A host shifts one on/off bit per channel in through a serial data line, strobing a serial clock. A latch strobe then commits the shifted word to the on/off register that drives the channel enables. A blanking input overrides all enables while it is high. The analog parts (current setting, open-LED comparators, thermal sensing) stay outside the block and arrive as digital inputs.

The same latch strobe turns the shift register into a status read port. In the cycle it commits the on/off word, it loads the shift register with a status word, and the host clocks that word out through the serial output. The status word holds one open-LED flag per channel. When the thermal warning is active, every bit of the word is 1. While blanking is low the status follows the live detector inputs. When blanking rises, the status freezes and stays frozen until blanking falls again.

Several instances form a chain when the serial output of one feeds the serial input of the next. The strobe, clock and blanking lines are shared. The serial strobe inputs (`sclk`, `lat`, `blank`) are sampled on `clk`, and the block acts on the rising edges it detects there. Each such edge takes effect two `clk` edges after the input changes.

Top module: `led_switch_reg`

## Requirements
- R1: On each detected rising edge of `sclk` with no rising edge of `lat` in the same cycle, the shift register moves one place toward bit N-1, and the sampled `sin` enters bit 0.
- R2: `sout` always shows shift-register bit N-1. It changes only after a detected rising edge of `sclk` or `lat`.
- R3: On a detected rising edge of `lat`, the on/off register takes the whole shift register. In the same cycle the shift register takes the status word. If `sclk` and `lat` rise in the same cycle, the load wins and no shift occurs.
- R4: While the sampled `blank` is 1, every `chan_en` bit is 0. While it is 0, `chan_en[n]` equals on/off register bit n.
- R5: While the sampled `blank` is 0, the status word follows the live detector inputs. From the rising edge of `blank` until it falls again, the status word holds the value it had before that edge.
- R6: Status bit n is 1 when `chan_en[n]` is 1 and `open_det[n]` is 1. Otherwise it is 0, provided `therm_warn` is 0.
- R7: While `therm_warn` is 1, all N status bits are 1, whatever the values of `open_det` and `chan_en`.
- R8: A second `lat` pulse, with no shifting since the first one, copies the status word into the on/off register. The block does nothing to prevent this.
- R9: A synchronous active-high `rst` clears the shift register, the on/off register and the status word. The sampled `blank` is reset to 1 so that `chan_en` stays 0.
- R10: Two instances chained through `sout`→`sin` act as one 2N-bit register. The first bit shifted ends in bit N-1 of the far instance, and the far instance's status is read out first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sin | input | 1 | Serial data in |
| sclk | input | 1 | Serial shift clock, acted on at its rising edge |
| lat | input | 1 | Latch strobe, acted on at its rising edge |
| blank | input | 1 | High forces all channels off and freezes status |
| open_det | input | N | Per-channel comparator: 1 = output voltage below open threshold |
| therm_warn | input | 1 | Thermal warning from the temperature sensor |
| sout | output | 1 | Serial data out, shift-register bit N-1 |
| chan_en | output | N | Registered per-channel sink enables |

## Verification
The bench drives a two-deep chain. It targets the double-duty latch strobe first. A design that skipped the status load would read back stale shift data. One that gave the serial clock priority over a coincident strobe would return a status word shifted by one place. A second strobe that failed to carry the status into the on/off register would leave the old enables lit. The bench also changes the detector inputs after blanking rises. A status that is not frozen would then report the new values. Open-LED flags on channels that are switched off must stay clear, a masking error that would show up as extra 1 bits. Under a thermal warning the bench expects the whole word to be all 1s.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  // index of each serial control strobe in the sampled control vector
  localparam int CTL_SCLK  = 0;
  localparam int CTL_LAT   = 1;
  localparam int CTL_BLANK = 2;
  localparam int NUM_CTL   = 3;
  // reset level of each strobe: blanking starts asserted
  localparam logic [NUM_CTL-1:0] CTL_RST_LVL = 3'b100;
endpackage

// File: rtl/lsr_ctl_edge.sv
module lsr_ctl_edge #(
  parameter int NUM = 3,
  parameter logic [NUM-1:0] RST_LVL = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] raw,
  output logic [NUM-1:0] level,
  output logic [NUM-1:0] rise
);
  logic [NUM-1:0] prev;

  for (genvar i = 0; i < NUM; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst) begin
        level[i] <= RST_LVL[i];
        prev[i]  <= RST_LVL[i];
      end else begin
        level[i] <= raw[i];
        prev[i]  <= level[i];
      end
    end
    assign rise[i] = level[i] & ~prev[i];
  end
endmodule

// File: rtl/lsr_shifter.sv
module lsr_shifter #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         load_en,
  input  logic         ser_in,
  input  logic [N-1:0] load_val,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load_en) begin
      q <= load_val;
    end else if (shift_en) begin
      q <= {q[N-2:0], ser_in};
    end
  end
endmodule

// File: rtl/lsr_onoff_gate.sv
module lsr_onoff_gate #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit,
  input  logic [N-1:0] commit_val,
  input  logic         blank_lvl,
  output logic [N-1:0] onoff,
  output logic [N-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst) onoff <= '0;
    else if (commit) onoff <= commit_val;
  end

  for (genvar c = 0; c < N; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) en[c] <= 1'b0;
      else     en[c] <= onoff[c] & ~blank_lvl;
    end
  end
endmodule

// File: rtl/lsr_status.sv
module lsr_status #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         blank_lvl,
  input  logic [N-1:0] det,
  input  logic         warn,
  input  logic [N-1:0] en,
  output logic [N-1:0] status
);
  logic [N-1:0] live;

  always_comb begin
    if (warn) live = '1;
    else      live = det & en;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else if (!blank_lvl) status <= live;
  end
endmodule

// File: rtl/led_switch_reg.sv
module led_switch_reg
  import lsr_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sin,
  input  logic         sclk,
  input  logic         lat,
  input  logic         blank,
  input  logic [N-1:0] open_det,
  input  logic         therm_warn,
  output logic         sout,
  output logic [N-1:0] chan_en
);
  logic [NUM_CTL-1:0] ctl_lvl, ctl_rise;
  logic               sin_q, warn_q;
  logic [N-1:0]       det_q, shreg, onoff, status;
  logic               sclk_rise, lat_rise, blank_lvl;

  lsr_ctl_edge #(.NUM(NUM_CTL), .RST_LVL(CTL_RST_LVL)) u_edge (
    .clk(clk), .rst(rst),
    .raw({blank, lat, sclk}),
    .level(ctl_lvl), .rise(ctl_rise)
  );

  assign sclk_rise = ctl_rise[CTL_SCLK];
  assign lat_rise  = ctl_rise[CTL_LAT];
  assign blank_lvl = ctl_lvl[CTL_BLANK];

  // data inputs share the sampling stage of the strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      sin_q  <= 1'b0;
      warn_q <= 1'b0;
      det_q  <= '0;
    end else begin
      sin_q  <= sin;
      warn_q <= therm_warn;
      det_q  <= open_det;
    end
  end

  lsr_shifter #(.N(N)) u_shift (
    .clk(clk), .rst(rst),
    .shift_en(sclk_rise), .load_en(lat_rise),
    .ser_in(sin_q), .load_val(status), .q(shreg)
  );

  lsr_onoff_gate #(.N(N)) u_gate (
    .clk(clk), .rst(rst),
    .commit(lat_rise), .commit_val(shreg),
    .blank_lvl(blank_lvl), .onoff(onoff), .en(chan_en)
  );

  lsr_status #(.N(N)) u_stat (
    .clk(clk), .rst(rst),
    .blank_lvl(blank_lvl), .det(det_q), .warn(warn_q),
    .en(chan_en), .status(status)
  );

  assign sout = shreg[N-1];
endmodule

// File: rtl/led_switch_reg_chk.sv
module led_switch_reg_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         sclk_rise,
  input logic         lat_rise,
  input logic         blank_lvl,
  input logic         sin_q,
  input logic         warn_q,
  input logic         sout,
  input logic [N-1:0] chan_en,
  input logic [N-1:0] shreg,
  input logic [N-1:0] onoff,
  input logic [N-1:0] status
);
  assert_shift_R1: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !lat_rise) |=> shreg == {$past(shreg[N-2:0]), $past(sin_q)});

  assert_sout_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!sclk_rise && !lat_rise) |=> $stable(sout));

  assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
    lat_rise |=> onoff == $past(shreg));

  assert_status_load_R3: assert property (@(posedge clk) disable iff (rst)
    lat_rise |=> shreg == $past(status));

  assert_blank_off_R4: assert property (@(posedge clk) disable iff (rst)
    blank_lvl |=> chan_en == '0);

  assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    blank_lvl |=> $stable(status));

  assert_warn_ones_R7: assert property (@(posedge clk) disable iff (rst)
    (!blank_lvl && warn_q) |=> (&status));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (chan_en == '0 && shreg == '0 && status == '0));
endmodule

bind led_switch_reg led_switch_reg_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst),
  .sclk_rise(sclk_rise), .lat_rise(lat_rise), .blank_lvl(blank_lvl),
  .sin_q(sin_q), .warn_q(warn_q), .sout(sout), .chan_en(chan_en),
  .shreg(shreg), .onoff(onoff), .status(status)
);

// File: tb/led_switch_reg_bench.sv
module led_switch_reg_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sin = 1'b0, sclk = 1'b0, lat = 1'b0, blank = 1'b1;
  logic [N-1:0] det_a = '0, det_b = '0;
  logic warn_a = 1'b0, warn_b = 1'b0;
  logic mid, sout_end;
  logic [N-1:0] en_a, en_b;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // near instance receives the bench data, far instance drives the chain output
  led_switch_reg #(.N(N)) u_led_switch_reg (
    .clk(clk), .rst(rst), .sin(sin), .sclk(sclk), .lat(lat), .blank(blank),
    .open_det(det_a), .therm_warn(warn_a), .sout(mid), .chan_en(en_a));

  led_switch_reg #(.N(N)) u_led_switch_reg_far (
    .clk(clk), .rst(rst), .sin(mid), .sclk(sclk), .lat(lat), .blank(blank),
    .open_det(det_b), .therm_warn(warn_b), .sout(sout_end), .chan_en(en_b));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk();
    sclk = 1'b1; step(4);
    sclk = 1'b0; step(4);
  endtask

  task automatic pulse_lat();
    lat = 1'b1; step(4);
    lat = 1'b0; step(4);
  endtask

  task automatic set_blank(input logic v);
    blank = v; step(8);
  endtask

  task automatic shift_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      sin = w[i];
      pulse_sclk();
    end
    sin = 1'b0;
  endtask

  task automatic read_word(output logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      w[i] = sout_end;
      pulse_sclk();
    end
  endtask

  task automatic t_reset();
    step(4);
    rst = 1'b0;
    step(4);
    check("R9 sout after reset", {31'd0, sout_end}, 32'd0);
    check("R9 enables after reset", {en_b, en_a}, 32'd0);
  endtask

  task automatic t_write_enable();
    shift_word(32'h1234_A5C3);
    pulse_lat();
    check("R4 blank high forces off", {en_b, en_a}, 32'd0);
    set_blank(1'b0);
    check("R1 R3 R10 chained enables", {en_b, en_a}, 32'h1234_A5C3);
    set_blank(1'b1);
    check("R4 blank high again", {en_b, en_a}, 32'd0);
  endtask

  task automatic t_status_read();
    logic [31:0] rd;
    det_a = 16'hFFFF; det_b = 16'h0F0F;
    set_blank(1'b0);
    set_blank(1'b1);
    det_a = 16'h0000; det_b = 16'hFFFF;  // must not reach the frozen status
    step(8);
    pulse_lat();
    read_word(rd);
    check("R5 R6 masked, frozen status", rd, 32'h0204_A5C3);
    det_a = '0; det_b = '0;
  endtask

  task automatic t_double_latch();
    shift_word(32'hFFFF_FFFF);
    pulse_lat();
    det_a = 16'h00F0; det_b = 16'h8001;
    set_blank(1'b0);
    check("R4 all channels on", {en_b, en_a}, 32'hFFFF_FFFF);
    set_blank(1'b1);
    det_a = '0; det_b = '0;
    shift_word(32'h0000_0011);
    pulse_lat();
    pulse_lat();
    set_blank(1'b0);
    check("R8 second strobe loads status", {en_b, en_a}, 32'h8001_00F0);
  endtask

  task automatic t_thermal();
    logic [31:0] rd;
    warn_b = 1'b1;
    step(8);
    set_blank(1'b1);
    warn_b = 1'b0;
    step(8);
    // coincident strobes: load must win over shift
    sclk = 1'b1; lat = 1'b1; step(4);
    sclk = 1'b0; lat = 1'b0; step(4);
    check("R3 coincident commit", {31'd0, sout_end}, 32'd1);
    read_word(rd);
    check("R7 R3 warn word unshifted", rd, 32'hFFFF_0000);
  endtask

  task automatic t_sout();
    logic [31:0] w = 32'h8000_0000;
    for (int i = 31; i >= 1; i--) begin
      sin = w[i];
      pulse_sclk();
    end
    check("R2 R10 sout before last shift", {31'd0, sout_end}, 32'd0);
    sin = w[0];
    pulse_sclk();
    check("R2 R10 sout after 32 shifts", {31'd0, sout_end}, 32'd1);
    set_blank(1'b0);
    set_blank(1'b1);
    check("R2 sout steady without strobes", {31'd0, sout_end}, 32'd1);
  endtask

  task automatic t_mid_reset();
    shift_word(32'hFFFF_FFFF);
    pulse_lat();
    set_blank(1'b0);
    rst = 1'b1; step(4);
    rst = 1'b0; step(4);
    check("R9 enables cleared by reset", {en_b, en_a}, 32'd0);
    check("R9 sout cleared by reset", {31'd0, sout_end}, 32'd0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_write_enable();
    t_status_read();
    t_double_latch();
    t_thermal();
    t_sout();
    t_mid_reset();
    finish_run();
  end
endmodule